// File: doc/BRIEF.md
# Memory Pattern Scrubber

The scrubber keeps a byte-wide on-chip data memory in a known state and repairs cells whose contents have been disturbed. After reset, or after a restart request, it writes a fixed pattern into every location of its window, one location per clock. It then walks the window in a loop that does not end: it reads each location, compares the returned byte with the pattern that belongs there, and writes the pattern back whenever the two differ.

The low part of the window holds four register banks of eight bytes each, and their patterns alternate from one bank to the next. Everything above the banks, up to a configurable last address, is general data holding one common pattern. Every repair also produces an error record on a valid/ready interface. The record carries the address, the byte that was read, the byte that was expected and a running error count. The block drives a single-port synchronous RAM whose read data arrives one clock after the address.

Top module: `mem_scrub`

## Requirements
- R1: Once reset is released, the fill phase writes address 0 first and then each following address in turn, one per clock, up to and including the last address. With defaults this is 256 writes.
- R2: Register bank n covers addresses 8n to 8n+7, and address bit 3 selects its pattern. Banks 0 and 2 (bit 3 = 0) are filled with 0xAA and banks 1 and 3 (bit 3 = 1) with 0x55.
- R3: Every address from 0x20 up to the last address is filled with 0x55.
- R4: After the fill phase, the scrub phase reads the addresses in ascending order and wraps from the last address back to 0, without end. It makes no write and raises no record while the memory matches.
- R5: The read data is compared in the clock after the read address is driven. On a mismatch the expected byte is written to that same address in that clock.
- R6: Each mismatch raises exactly one record holding the address, the observed byte, the expected byte and a 16-bit count that includes this error. The count is 1 for the first error after reset or restart. The record stays valid and unchanged until it is accepted, and it drops in the clock after acceptance.
- R7: While a record waits for acceptance, the scrubber holds its read address and neither advances nor writes.
- R8: A restart puts the block into the fill phase at address 0 on the next clock, clears the error count and withdraws any pending record. A restart in a compare clock suppresses that clock's repair write and its record.
- R9: During reset, the write enable and the record valid are low.
- R10: The last address is a parameter. With it set to 0x80, the fill and the scrub loop never go past 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Synchronous request to refill and clear the count |
| mem_addr | output | 8 | RAM address |
| mem_wdata | output | 8 | RAM write data (expected pattern) |
| mem_we | output | 1 | RAM write enable |
| mem_rdata | input | 8 | RAM read data, one clock after the address |
| rpt_valid | output | 1 | Error record valid |
| rpt_ready | input | 1 | Error record accepted |
| rpt_addr | output | 8 | Address of the failing cell |
| rpt_obs | output | 8 | Byte that was read |
| rpt_exp | output | 8 | Byte that was expected |
| rpt_count | output | 16 | Running error count including this record |

## Verification
A restart and a repair can arrive in the same clock. The bench sets this up by corrupting a bank cell, waiting until the scrubber drives that cell's read address, and raising restart in the following compare clock. Restart must win. The write enable falls within that clock, no record appears, the next clock shows a fill write at address 0, and the next error after the refill reports a count of 1.

// File: rtl/mem_scrub_pkg.sv
// Shared types for the memory pattern scrubber.
package mem_scrub_pkg;
    // Walker phases: filling, issuing a read, comparing returned data
    typedef enum logic [1:0] {
        PH_FILL  = 2'd0,
        PH_READ  = 2'd1,
        PH_CHECK = 2'd2
    } phase_t;
endpackage

// File: rtl/scrub_expect.sv
// Expected-byte lookup. Addresses below NUM_BANKS*BANK_BYTES belong to
// register banks whose pattern alternates per bank; everything above is
// general data. Assumes BANK_BYTES is a power of two.
module scrub_expect #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int BANK_BYTES = 8,
    parameter int NUM_BANKS  = 4,
    parameter logic [DATA_W-1:0] PAT_EVEN = 8'hAA,
    parameter logic [DATA_W-1:0] PAT_ODD  = 8'h55,
    parameter logic [DATA_W-1:0] PAT_DATA = 8'h55
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] exp_byte
);
    localparam int BANK_SH = $clog2(BANK_BYTES);
    localparam logic [ADDR_W:0] BANK_END = (ADDR_W+1)'(BANK_BYTES * NUM_BANKS);

    // Select the pattern for the region holding addr
    always_comb begin
        if ({1'b0, addr} < BANK_END)
            exp_byte = addr[BANK_SH] ? PAT_ODD : PAT_EVEN;
        else
            exp_byte = PAT_DATA;
    end
endmodule

// File: rtl/scrub_walker.sv
// Phase and address sequencer. Fill walks 0..LAST_ADDR writing once per
// clock; scrub alternates read and check clocks, wrapping at LAST_ADDR.
// A read is held (not advanced) while the report slot is occupied.
module scrub_walker
    import mem_scrub_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] LAST_ADDR = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              hold,
    output phase_t            phase,
    output logic [ADDR_W-1:0] addr
);
    // Advance phase and address
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase <= PH_FILL;
            addr  <= '0;
        end else begin
            case (phase)
                PH_FILL: begin
                    if (addr == LAST_ADDR) begin
                        phase <= PH_READ;
                        addr  <= '0;
                    end else begin
                        addr <= addr + 1'b1;
                    end
                end
                PH_READ: begin
                    if (!hold) phase <= PH_CHECK;
                end
                PH_CHECK: begin
                    phase <= PH_READ;
                    addr  <= (addr == LAST_ADDR) ? '0 : addr + 1'b1;
                end
                default: begin
                    phase <= PH_FILL;
                    addr  <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/scrub_report.sv
// One-deep error record with running count. Assumes load only arrives
// when the slot is free or being accepted (the walker guarantees it).
module scrub_report #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_obs,
    input  logic [DATA_W-1:0] in_exp,
    input  logic              ready,
    output logic              valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_obs,
    output logic [DATA_W-1:0] out_exp,
    output logic [CNT_W-1:0]  out_count
);
    logic [CNT_W-1:0] err_cnt;

    // Running error count, cleared by reset and restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart) err_cnt <= '0;
        else if (load)         err_cnt <= err_cnt + 1'b1;
    end

    // Record register with valid/ready handshake
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            valid     <= 1'b0;
            out_addr  <= '0;
            out_obs   <= '0;
            out_exp   <= '0;
            out_count <= '0;
        end else if (load) begin
            valid     <= 1'b1;
            out_addr  <= in_addr;
            out_obs   <= in_obs;
            out_exp   <= in_exp;
            out_count <= err_cnt + 1'b1;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/mem_scrub.sv
// Memory pattern scrubber top. Drives a single-port RAM with one-clock
// read latency, fills it with region patterns, then checks and repairs
// forever, reporting each repair. Restart outranks a same-clock repair.
module mem_scrub
    import mem_scrub_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 16,
    parameter int BANK_BYTES = 8,
    parameter int NUM_BANKS  = 4,
    parameter logic [ADDR_W-1:0] LAST_ADDR = 8'hFF,
    parameter logic [DATA_W-1:0] PAT_EVEN  = 8'hAA,
    parameter logic [DATA_W-1:0] PAT_ODD   = 8'h55,
    parameter logic [DATA_W-1:0] PAT_DATA  = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rpt_valid,
    input  logic              rpt_ready,
    output logic [ADDR_W-1:0] rpt_addr,
    output logic [DATA_W-1:0] rpt_obs,
    output logic [DATA_W-1:0] rpt_exp,
    output logic [CNT_W-1:0]  rpt_count
);
    phase_t            phase;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] exp_byte;
    logic              in_fill;
    logic              mismatch;
    logic              repair;
    logic              slot_busy;

    scrub_walker #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_walker (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .hold(slot_busy), .phase(phase), .addr(cur_addr)
    );

    scrub_expect #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_BYTES(BANK_BYTES),
        .NUM_BANKS(NUM_BANKS), .PAT_EVEN(PAT_EVEN), .PAT_ODD(PAT_ODD),
        .PAT_DATA(PAT_DATA)
    ) u_expect (.addr(cur_addr), .exp_byte(exp_byte));

    // Compare, repair gating and RAM drive
    always_comb begin
        in_fill   = (phase == PH_FILL);
        mismatch  = (phase == PH_CHECK) && (mem_rdata != exp_byte);
        repair    = mismatch && !restart;
        slot_busy = rpt_valid && !rpt_ready;
        mem_addr  = cur_addr;
        mem_wdata = exp_byte;
        mem_we    = rst_n && (in_fill || repair);
    end

    scrub_report #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_report (
        .clk(clk), .rst_n(rst_n), .restart(restart), .load(repair),
        .in_addr(cur_addr), .in_obs(mem_rdata), .in_exp(exp_byte),
        .ready(rpt_ready), .valid(rpt_valid), .out_addr(rpt_addr),
        .out_obs(rpt_obs), .out_exp(rpt_exp), .out_count(rpt_count)
    );
endmodule

// File: rtl/mem_scrub_checker.sv
// Temporal checks on the scrubber ports and its fill flag.
module mem_scrub_checker #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 16,
    parameter int BANK_BYTES = 8,
    parameter int NUM_BANKS  = 4,
    parameter logic [ADDR_W-1:0] LAST_ADDR = 8'hFF,
    parameter logic [DATA_W-1:0] PAT_DATA  = 8'h55
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart,
    input logic              in_fill,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_we,
    input logic              rpt_valid,
    input logic              rpt_ready,
    input logic [ADDR_W-1:0] rpt_addr,
    input logic [DATA_W-1:0] rpt_obs,
    input logic [DATA_W-1:0] rpt_exp,
    input logic [CNT_W-1:0]  rpt_count
);
    localparam logic [ADDR_W-1:0] DATA_LO = ADDR_W'(BANK_BYTES * NUM_BANKS);

    assert_fill_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_fill && !restart && mem_addr != LAST_ADDR |=>
        in_fill && mem_addr == $past(mem_addr) + 1'b1);

    assert_data_pattern_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && mem_addr >= DATA_LO |-> mem_wdata == PAT_DATA);

    assert_repair_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && !in_fill |-> mem_addr == $past(mem_addr) && !$past(mem_we));

    assert_record_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid && !rpt_ready && !restart |=>
        rpt_valid && $stable(rpt_addr) && $stable(rpt_obs) &&
        $stable(rpt_exp) && $stable(rpt_count));

    assert_record_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid && rpt_ready && !restart |=> !rpt_valid);

    assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid && !rpt_ready && !restart |=> $stable(mem_addr) && !mem_we);

    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> in_fill && mem_addr == '0 && !rpt_valid);

    assert_reset_R9: assert property (@(posedge clk)
        !rst_n |=> !rpt_valid);
endmodule

bind mem_scrub mem_scrub_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .BANK_BYTES(BANK_BYTES),
    .NUM_BANKS(NUM_BANKS), .LAST_ADDR(LAST_ADDR), .PAT_DATA(PAT_DATA)
) u_chk (
    .clk(clk), .rst_n(rst_n), .restart(restart), .in_fill(in_fill),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_addr(rpt_addr),
    .rpt_obs(rpt_obs), .rpt_exp(rpt_exp), .rpt_count(rpt_count)
);

// File: tb/mem_scrub_bench.sv
// Bench: full-window scrubber with corruptible RAM, plus a reduced-window
// instance; vector table of corruptions then directed restart test.
module mem_scrub_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, restart, ready;
    logic [7:0] addr_a, wdata_a, rdata_a, raddr, robs, rexp;
    logic       we_a, valid;
    logic [15:0] rcount;
    logic       cor_en;
    logic [7:0] cor_addr, cor_data;
    logic [7:0] ram_a [256];

    logic [7:0] addr_b, wdata_b, rdata_b, raddr_b, robs_b, rexp_b;
    logic       we_b, valid_b;
    logic [15:0] rcount_b;
    logic [7:0] ram_b [256];
    logic [7:0] max_b = 8'h00;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    mem_scrub u_mem_scrub (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .mem_addr(addr_a), .mem_wdata(wdata_a), .mem_we(we_a), .mem_rdata(rdata_a),
        .rpt_valid(valid), .rpt_ready(ready), .rpt_addr(raddr),
        .rpt_obs(robs), .rpt_exp(rexp), .rpt_count(rcount)
    );

    mem_scrub #(.LAST_ADDR(8'h80)) u_mem_scrub_small (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .mem_addr(addr_b), .mem_wdata(wdata_b), .mem_we(we_b), .mem_rdata(rdata_b),
        .rpt_valid(valid_b), .rpt_ready(1'b1), .rpt_addr(raddr_b),
        .rpt_obs(robs_b), .rpt_exp(rexp_b), .rpt_count(rcount_b)
    );

    // RAM models with a bench corruption port on the main one
    always_ff @(posedge clk) begin
        if (we_a)   ram_a[addr_a] <= wdata_a;
        if (cor_en) ram_a[cor_addr] <= cor_data;
        rdata_a <= ram_a[addr_a];
        if (we_b)   ram_b[addr_b] <= wdata_b;
        rdata_b <= ram_b[addr_b];
    end

    // Highest address the reduced instance ever drives
    always @(negedge clk) if (rst_n && addr_b > max_b) max_b = addr_b;

    function automatic logic [7:0] exp_of(input int a);
        if (a < 32) return a[3] ? 8'h55 : 8'hAA;
        return 8'h55;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Corruption vectors: address, injected byte, expected byte
    localparam logic [23:0] VEC [6] = '{
        {8'h03, 8'h00, 8'hAA}, {8'h0A, 8'hFF, 8'h55}, {8'h12, 8'h55, 8'hAA},
        {8'h1F, 8'hAA, 8'h55}, {8'h20, 8'h54, 8'h55}, {8'hFF, 8'h00, 8'h55}
    };

    task automatic corrupt(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); cor_en = 1'b1; cor_addr = a; cor_data = d;
        @(negedge clk); cor_en = 1'b0;
    endtask

    task automatic wait_valid();
        for (int t = 0; t < 2000 && !valid; t++) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        int n, bad, wraps, writes, reps;
        logic [7:0] prev, held;
        rst_n = 1'b0; restart = 1'b0; ready = 1'b0;
        cor_en = 1'b0; cor_addr = 8'h00; cor_data = 8'h00;
        repeat (3) @(negedge clk);
        check(!we_a && !valid, "R9 reset outputs", {we_a, valid}, 0);
        rst_n = 1'b1;
        #1;
        check(we_a && addr_a == 8'h00, "R1 first fill write", addr_a, 0);

        // R1: count fill clocks
        n = 0;
        while (we_a && n < 400) begin n++; @(negedge clk); #1; end
        check(n == 256, "R1 fill length", n, 256);

        bad = 0;
        for (int i = 0; i < 32; i++) if (ram_a[i] != exp_of(i)) bad++;
        check(bad == 0, "R2 bank patterns", bad, 0);
        bad = 0;
        for (int i = 32; i < 256; i++) if (ram_a[i] != 8'h55) bad++;
        check(bad == 0, "R3 data pattern", bad, 0);

        // R4: clean lap, ascending with wrap, no writes, no records
        wraps = 0; writes = 0; reps = 0; prev = addr_a;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (we_a) writes++;
            if (valid) reps++;
            if (prev == 8'hFF && addr_a == 8'h00) wraps++;
            prev = addr_a;
        end
        check(writes == 0 && reps == 0, "R4 clean lap quiet", writes + reps, 0);
        check(wraps >= 1, "R4 wrap to zero", wraps, 1);
        check(max_b == 8'h80 && ram_b[8'h80] == 8'h55, "R10 reduced window", max_b, 8'h80);

        // Vector table: corrupt, await record, stall, accept, verify repair
        for (int i = 0; i < 6; i++) begin
            corrupt(VEC[i][23:16], VEC[i][15:8]);
            wait_valid();
            check(valid, "R6 record raised", valid, 1);
            check(raddr == VEC[i][23:16], "R6 record addr", raddr, VEC[i][23:16]);
            check(robs == VEC[i][15:8], "R6 record observed", robs, VEC[i][15:8]);
            check(rexp == VEC[i][7:0], "R2 R3 expected byte", rexp, VEC[i][7:0]);
            check(rcount == 16'(i + 1), "R6 running count", rcount, i + 1);
            held = addr_a;
            repeat (3) @(negedge clk);
            check(valid && addr_a == held && !we_a, "R7 stall while pending", addr_a, held);
            ready = 1'b1;
            @(negedge clk);
            ready = 1'b0;
            check(!valid, "R6 record drops after accept", valid, 0);
            check(ram_a[VEC[i][23:16]] == VEC[i][7:0], "R5 cell repaired",
                  ram_a[VEC[i][23:16]], VEC[i][7:0]);
        end

        // R8: restart in the same clock as a repair
        corrupt(8'h05, 8'h00);
        n = 0;
        while (!(addr_a == 8'h05 && !we_a) && n < 2000) begin n++; @(negedge clk); end
        @(negedge clk);
        check(we_a, "R5 repair in compare clock", we_a, 1);
        restart = 1'b1;
        #1;
        check(!we_a, "R8 restart suppresses repair", we_a, 0);
        @(negedge clk);
        restart = 1'b0;
        check(we_a && addr_a == 8'h00 && !valid, "R8 refill from zero", addr_a, 0);
        n = 0;
        while (we_a && n < 400) begin n++; @(negedge clk); #1; end
        check(ram_a[8'h05] == 8'hAA, "R8 refill restores cell", ram_a[8'h05], 8'hAA);
        corrupt(8'h30, 8'h00);
        wait_valid();
        check(valid && rcount == 16'd1, "R8 count cleared", rcount, 1);
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end
endmodule